// File: doc/BRIEF.md
# Inner Data Label Parser

This block sits on the receive path of an encapsulating switch, after the outer link header has been removed. It watches the inner header as a byte stream that starts with the inner destination MAC address, then the inner source MAC address, and then a data label tag. From the tag type that follows the source address, it decides whether the frame carries a plain 12-bit VLAN label or a 24-bit fine-grained label. A fine-grained label is built from two stacked tags. Any other type code is rejected.

For each frame, exactly one result record is produced. The record holds a format code, the label value, the forwarding priority and drop-eligible bit taken from the first tag body, the inner destination MAC, and a discard decision with a truncation flag. The result is produced as soon as enough bytes have arrived to decide. Bytes after that point, up to the end of the frame, are consumed without effect. Downstream routing or filtering logic uses the record. A frame with a discard result must not be forwarded.

Top module: `inner_label_parser`

## Requirements
- R1: After reset, res_valid is 0. in_ready is 1 in every cycle, so a byte is taken on every clock edge where in_valid is 1.
- R2: The byte taken with in_sof=1 is frame position 0. Positions 0 to 5 form res_dmac, with position 0 in bits 47:40. Bytes taken outside a frame without in_sof are ignored.
- R3: A type code of 0x8100 at positions 12 (high byte) and 13 gives a VLAN result one cycle after position 15 is taken. In that result, res_fmt=1, res_label={12'h000, body[11:0]}, res_prio=body[15:13], res_dei=body[12] and res_discard=0, where body is {pos14, pos15}.
- R4: A type code of 0x893B at positions 12-13, followed by 0x893B again at positions 16-17, gives a fine-grained result one cycle after position 19 is taken. In that result, res_fmt=2, res_label={body1[11:0], body2[11:0]}, with body1 = {pos14, pos15} and body2 = {pos18, pos19}. res_prio and res_dei come from body1[15:13] and body1[12], and res_discard=0.
- R5: Any other type code at positions 12-13 gives, one cycle after position 13 is taken, res_fmt=3 and res_discard=1, with res_label, res_prio and res_dei all 0.
- R6: In a fine-grained frame whose second type code at positions 16-17 is not 0x893B, the result comes one cycle after position 17 is taken. It has res_fmt=3, res_discard=1, res_trunc=0, and label, priority and DEI all 0.
- R7: A frame whose in_eof byte arrives before its deciding position gives a result one cycle after that byte is taken. The result has res_fmt=3, res_discard=1, res_trunc=1, and label, priority and DEI all 0. res_dmac holds the destination bytes received, and any missing bytes read as 0.
- R8: Each frame yields exactly one result. Bytes after the deciding position, even ones that look like tags, cause no further result.
- R9: Cycles with in_valid=0 do not advance the frame position. The result timing of R3 to R7 is counted in bytes taken.
- R10: res_valid is a one-cycle pulse for each result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted (always 1) |
| in_data | input | 8 | Input byte |
| in_sof | input | 1 | Byte is the first of a frame |
| in_eof | input | 1 | Byte is the last of a frame |
| res_valid | output | 1 | Result record valid pulse |
| res_fmt | output | 2 | 1 VLAN, 2 fine-grained, 3 bad |
| res_label | output | 24 | Label value |
| res_prio | output | 3 | Forwarding priority |
| res_dei | output | 1 | Drop-eligible bit |
| res_discard | output | 1 | Frame must be dropped |
| res_trunc | output | 1 | Frame ended before a decision |
| res_dmac | output | 48 | Inner destination MAC |

## Verification
The hardest cases to reach are the ones where the end marker lands exactly on, or one byte before, a deciding position. Examples are a VLAN frame ending at position 13 with a valid type code, or a bad-type frame ending at position 13. There the truncation outcome and the format decision compete in the same cycle. The stimulus reaches these cases by cutting each frame kind at every length from one byte up to its full header. It also mixes idle cycles into the stream and stray bytes before the start marker, which moves the deciding byte to a different clock cycle. Trailing payload that repeats valid tag codes shows that a decided frame cannot produce a second result.

// File: rtl/lbl_pkg.sv
`timescale 1ns/1ps
package lbl_pkg;
  localparam int TAG_BODY_W = 16;
  localparam int PART_W     = 12;
  localparam int LABEL_W    = 2 * PART_W;

  typedef enum logic [1:0] {
    FMT_NONE = 2'd0,
    FMT_VL   = 2'd1,
    FMT_FGL  = 2'd2,
    FMT_BAD  = 2'd3
  } lbl_fmt_e;
endpackage

// File: rtl/lbl_pos_ctr.sv
`timescale 1ns/1ps
module lbl_pos_ctr #(
  parameter int POS_MAX = 20,
  parameter int POS_W   = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat,
  input  logic             sof,
  input  logic             eof,
  input  logic             fire,
  output logic [POS_W-1:0] pos,
  output logic             active
);
  logic             in_frame_q, in_frame_d;
  logic             done_q, done_d;
  logic [POS_W-1:0] idx_q, idx_d;

  assign active = beat && (sof || (in_frame_q && !done_q));
  assign pos    = sof ? '0 : idx_q;

  always_comb begin
    in_frame_d = in_frame_q;
    done_d     = done_q;
    idx_d      = idx_q;
    if (beat) begin
      if (sof) begin
        in_frame_d = 1'b1;
        done_d     = fire;
        idx_d      = POS_W'(1);
      end else if (in_frame_q) begin
        if (idx_q != POS_W'(POS_MAX)) idx_d = idx_q + POS_W'(1);
        done_d = done_q | fire;
      end
      if (eof) begin
        in_frame_d = 1'b0;
        done_d     = 1'b0;
        idx_d      = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame_q <= 1'b0;
      done_q     <= 1'b0;
      idx_q      <= '0;
    end else if (beat) begin
      in_frame_q <= in_frame_d;
      done_q     <= done_d;
      idx_q      <= idx_d;
    end
  end
endmodule

// File: rtl/lbl_capture.sv
`timescale 1ns/1ps
module lbl_capture #(
  parameter int MAC_BYTES = 6,
  parameter int POS_W     = 5,
  parameter int TYPE_OFS  = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   active,
  input  logic                   sof,
  input  logic [POS_W-1:0]       pos,
  input  logic [7:0]             data,
  output logic [8*MAC_BYTES-1:0] dmac_nxt,
  output logic [15:0]            type1_q,
  output logic [15:0]            body1_q,
  output logic [7:0]             type2_hi_q,
  output logic [3:0]             body2_nib_q
);
  logic [8*MAC_BYTES-1:0] dmac_q;

  for (genvar g = 0; g < MAC_BYTES; g++) begin : g_mac
    localparam int LSB = 8 * (MAC_BYTES - 1 - g);
    logic [7:0] nb;
    always_comb begin
      nb = dmac_q[LSB +: 8];
      if (active && sof) nb = 8'h00;
      if (active && (pos == POS_W'(g))) nb = data;
    end
    assign dmac_nxt[LSB +: 8] = nb;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dmac_q <= '0;
    else if (active) dmac_q <= dmac_nxt;
  end

  logic en_t1h, en_t1l, en_b1h, en_b1l, en_t2h, en_b2h;
  assign en_t1h = active && (pos == POS_W'(TYPE_OFS));
  assign en_t1l = active && (pos == POS_W'(TYPE_OFS + 1));
  assign en_b1h = active && (pos == POS_W'(TYPE_OFS + 2));
  assign en_b1l = active && (pos == POS_W'(TYPE_OFS + 3));
  assign en_t2h = active && (pos == POS_W'(TYPE_OFS + 4));
  assign en_b2h = active && (pos == POS_W'(TYPE_OFS + 6));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      type1_q     <= '0;
      body1_q     <= '0;
      type2_hi_q  <= '0;
      body2_nib_q <= '0;
    end else begin
      if (en_t1h) type1_q[15:8]  <= data;
      if (en_t1l) type1_q[7:0]   <= data;
      if (en_b1h) body1_q[15:8]  <= data;
      if (en_b1l) body1_q[7:0]   <= data;
      if (en_t2h) type2_hi_q     <= data;
      if (en_b2h) body2_nib_q    <= data[3:0];
    end
  end
endmodule

// File: rtl/lbl_decide.sv
`timescale 1ns/1ps
module lbl_decide
  import lbl_pkg::*;
#(
  parameter int          POS_W    = 5,
  parameter int          TYPE_OFS = 12,
  parameter logic [15:0] VL_TYPE  = 16'h8100,
  parameter logic [15:0] FGL_TYPE = 16'h893B
) (
  input  logic               active,
  input  logic               eof,
  input  logic [POS_W-1:0]   pos,
  input  logic [7:0]         data,
  input  logic [15:0]        type1_q,
  input  logic [15:0]        body1_q,
  input  logic [7:0]         type2_hi_q,
  input  logic [3:0]         body2_nib_q,
  output logic               fire,
  output lbl_fmt_e           fmt,
  output logic [LABEL_W-1:0] label,
  output logic [2:0]         prio,
  output logic               dei,
  output logic               trunc
);
  localparam logic [POS_W-1:0] P_TYPE1 = POS_W'(TYPE_OFS + 1);
  localparam logic [POS_W-1:0] P_BODY1 = POS_W'(TYPE_OFS + 3);
  localparam logic [POS_W-1:0] P_TYPE2 = POS_W'(TYPE_OFS + 5);
  localparam logic [POS_W-1:0] P_BODY2 = POS_W'(TYPE_OFS + 7);

  logic [15:0] type1_now, type2_now, body1_now;
  logic        was_vl, was_fgl;

  assign type1_now = {type1_q[15:8], data};
  assign type2_now = {type2_hi_q, data};
  assign body1_now = {body1_q[15:8], data};
  assign was_vl    = (type1_q == VL_TYPE);
  assign was_fgl   = (type1_q == FGL_TYPE);

  always_comb begin
    fire  = 1'b0;
    fmt   = FMT_NONE;
    label = '0;
    prio  = '0;
    dei   = 1'b0;
    trunc = 1'b0;
    if (active) begin
      if (pos == P_TYPE1) begin
        if ((type1_now != VL_TYPE) && (type1_now != FGL_TYPE)) begin
          fire = 1'b1;
          fmt  = FMT_BAD;
        end
      end else if (pos == P_BODY1) begin
        if (was_vl) begin
          fire  = 1'b1;
          fmt   = FMT_VL;
          label = {{PART_W{1'b0}}, body1_now[PART_W-1:0]};
          prio  = body1_now[15:13];
          dei   = body1_now[12];
        end
      end else if (pos == P_TYPE2) begin
        if (was_fgl && (type2_now != FGL_TYPE)) begin
          fire = 1'b1;
          fmt  = FMT_BAD;
        end
      end else if (pos == P_BODY2) begin
        if (was_fgl) begin
          fire  = 1'b1;
          fmt   = FMT_FGL;
          label = {body1_q[PART_W-1:0], body2_nib_q, data};
          prio  = body1_q[15:13];
          dei   = body1_q[12];
        end
      end
      if (!fire && eof) begin
        fire  = 1'b1;
        fmt   = FMT_BAD;
        trunc = 1'b1;
      end
    end
  end
endmodule

// File: rtl/inner_label_parser.sv
`timescale 1ns/1ps
module inner_label_parser
  import lbl_pkg::*;
#(
  parameter int          MAC_BYTES = 6,
  parameter logic [15:0] VL_TYPE   = 16'h8100,
  parameter logic [15:0] FGL_TYPE  = 16'h893B
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [7:0]             in_data,
  input  logic                   in_sof,
  input  logic                   in_eof,
  output logic                   res_valid,
  output logic [1:0]             res_fmt,
  output logic [LABEL_W-1:0]     res_label,
  output logic [2:0]             res_prio,
  output logic                   res_dei,
  output logic                   res_discard,
  output logic                   res_trunc,
  output logic [8*MAC_BYTES-1:0] res_dmac
);
  localparam int TYPE_OFS = 2 * MAC_BYTES;
  localparam int POS_MAX  = TYPE_OFS + 8;
  localparam int POS_W    = $clog2(POS_MAX + 1);

  logic                   beat, active, fire, dec_dei, dec_trunc;
  logic [POS_W-1:0]       pos;
  logic [8*MAC_BYTES-1:0] dmac_nxt;
  logic [15:0]            type1_q, body1_q;
  logic [7:0]             type2_hi_q;
  logic [3:0]             body2_nib_q;
  lbl_fmt_e               dec_fmt;
  logic [LABEL_W-1:0]     dec_label;
  logic [2:0]             dec_prio;

  assign in_ready = 1'b1;
  assign beat     = in_valid && in_ready;

  lbl_pos_ctr #(.POS_MAX(POS_MAX), .POS_W(POS_W)) u_pos (
    .clk(clk), .rst_n(rst_n), .beat(beat), .sof(in_sof), .eof(in_eof),
    .fire(fire), .pos(pos), .active(active)
  );

  lbl_capture #(.MAC_BYTES(MAC_BYTES), .POS_W(POS_W), .TYPE_OFS(TYPE_OFS)) u_cap (
    .clk(clk), .rst_n(rst_n), .active(active), .sof(in_sof), .pos(pos),
    .data(in_data), .dmac_nxt(dmac_nxt), .type1_q(type1_q), .body1_q(body1_q),
    .type2_hi_q(type2_hi_q), .body2_nib_q(body2_nib_q)
  );

  lbl_decide #(.POS_W(POS_W), .TYPE_OFS(TYPE_OFS),
               .VL_TYPE(VL_TYPE), .FGL_TYPE(FGL_TYPE)) u_dec (
    .active(active), .eof(in_eof), .pos(pos), .data(in_data),
    .type1_q(type1_q), .body1_q(body1_q), .type2_hi_q(type2_hi_q),
    .body2_nib_q(body2_nib_q), .fire(fire), .fmt(dec_fmt), .label(dec_label),
    .prio(dec_prio), .dei(dec_dei), .trunc(dec_trunc)
  );

  logic                   vld_q, vld_d;
  lbl_fmt_e               fmt_q;
  logic [LABEL_W-1:0]     label_q;
  logic [2:0]             prio_q;
  logic                   dei_q, disc_q, trunc_q;
  logic [8*MAC_BYTES-1:0] dmac_q;

  assign vld_d = fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fmt_q   <= FMT_NONE;
      label_q <= '0;
      prio_q  <= '0;
      dei_q   <= 1'b0;
      disc_q  <= 1'b0;
      trunc_q <= 1'b0;
      dmac_q  <= '0;
    end else if (fire) begin
      fmt_q   <= dec_fmt;
      label_q <= dec_label;
      prio_q  <= dec_prio;
      dei_q   <= dec_dei;
      disc_q  <= (dec_fmt == FMT_BAD);
      trunc_q <= dec_trunc;
      dmac_q  <= dmac_nxt;
    end
  end

  assign res_valid   = vld_q;
  assign res_fmt     = fmt_q;
  assign res_label   = label_q;
  assign res_prio    = prio_q;
  assign res_dei     = dei_q;
  assign res_discard = disc_q;
  assign res_trunc   = trunc_q;
  assign res_dmac    = dmac_q;
endmodule

// File: rtl/lbl_parse_chk.sv
`timescale 1ns/1ps
module lbl_parse_chk
  import lbl_pkg::*;
(
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic         res_valid,
  input logic [1:0]   res_fmt,
  input logic [23:0]  res_label,
  input logic [2:0]   res_prio,
  input logic         res_dei,
  input logic         res_discard,
  input logic         res_trunc
);
  AST_RES_AFTER_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(in_valid && in_ready)); // R9

  AST_VL_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_fmt == FMT_VL) |-> (res_label[23:12] == 12'h000)); // R3

  AST_GOOD_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && (res_fmt == FMT_VL || res_fmt == FMT_FGL)) |-> (!res_discard && !res_trunc)); // R4

  AST_BAD_ZEROED: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_fmt == FMT_BAD) |-> (res_discard && res_label == '0 && res_prio == '0 && !res_dei)); // R5

  AST_TRUNC_IS_BAD: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_trunc) |-> (res_fmt == FMT_BAD)); // R7

  AST_FMT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_fmt != FMT_NONE)); // R8
endmodule

bind inner_label_parser lbl_parse_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .res_valid(res_valid), .res_fmt(res_fmt), .res_label(res_label),
  .res_prio(res_prio), .res_dei(res_dei), .res_discard(res_discard),
  .res_trunc(res_trunc)
);

// File: tb/inner_label_parser_tb_top.sv
`timescale 1ns/1ps
module inner_label_parser_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_sof, in_eof;
  logic [7:0]  in_data;
  logic        in_ready, res_valid, res_dei, res_discard, res_trunc;
  logic [1:0]  res_fmt;
  logic [23:0] res_label;
  logic [2:0]  res_prio;
  logic [47:0] res_dmac;

  inner_label_parser dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof), .res_valid(res_valid),
    .res_fmt(res_fmt), .res_label(res_label), .res_prio(res_prio),
    .res_dei(res_dei), .res_discard(res_discard), .res_trunc(res_trunc),
    .res_dmac(res_dmac)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0;
  int n_fail = 0;
  int n_res = 0;
  int r_cyc;
  logic [1:0] r_fmt; logic [23:0] r_label; logic [2:0] r_prio;
  logic r_dei, r_disc, r_trunc; logic [47:0] r_dmac;

  always @(negedge clk) begin
    if (rst_n === 1'b1 && res_valid === 1'b1) begin
      n_res++;
      r_cyc = cyc; r_fmt = res_fmt; r_label = res_label; r_prio = res_prio;
      r_dei = res_dei; r_disc = res_discard; r_trunc = res_trunc; r_dmac = res_dmac;
    end
  end

  logic [7:0] fb [0:39];
  int flen;
  int bcyc [0:39];

  logic [1:0] e_fmt; logic [23:0] e_label; logic [2:0] e_prio;
  logic e_dei, e_disc, e_trunc; logic [47:0] e_dmac; int e_pos;

  task automatic chk(input string rq, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic build(input logic [47:0] mac, input logic [15:0] t1, input logic [15:0] b1,
                       input logic [15:0] t2, input logic [15:0] b2, input int len, input logic [7:0] seed);
    for (int i = 0; i < 40; i++) fb[i] = seed + 8'(i * 37);
    for (int i = 0; i < 6; i++) fb[i] = mac[8*(5-i) +: 8];
    fb[12] = t1[15:8]; fb[13] = t1[7:0];
    fb[14] = b1[15:8]; fb[15] = b1[7:0];
    fb[16] = t2[15:8]; fb[17] = t2[7:0];
    fb[18] = b2[15:8]; fb[19] = b2[7:0];
    flen = len;
  endtask

  task automatic send(input bit gaps, input bit junk);
    n_res = 0;
    if (junk) begin
      for (int j = 0; j < 3; j++) begin
        @(posedge clk); #1;
        in_valid = 1'b1; in_data = 8'h81; in_sof = 1'b0; in_eof = (j == 2);
      end
    end
    for (int i = 0; i < flen; i++) begin
      if (gaps && (i % 3 == 2)) begin
        @(posedge clk); #1;
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
      end
      @(posedge clk); #1;
      in_valid = 1'b1; in_data = fb[i]; in_sof = (i == 0); in_eof = (i == flen - 1);
      bcyc[i] = cyc;
    end
    @(posedge clk); #1;
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic exp_dmac(input logic [47:0] mac, input int len);
    e_dmac = '0;
    for (int k = 0; k < 6; k++) if (k < len) e_dmac[8*(5-k) +: 8] = mac[8*(5-k) +: 8];
  endtask

  task automatic check_frame(input string rq);
    chk("R8", "result count", 64'(n_res), 64'd1);
    chk("R10", "valid low after pulse", 64'(res_valid), 64'd0);
    if (n_res == 1) begin
      chk(rq, "fmt", 64'(r_fmt), 64'(e_fmt));
      chk(rq, "label", 64'(r_label), 64'(e_label));
      chk(rq, "prio", 64'(r_prio), 64'(e_prio));
      chk(rq, "dei", 64'(r_dei), 64'(e_dei));
      chk(rq, "discard", 64'(r_disc), 64'(e_disc));
      chk(rq, "trunc", 64'(r_trunc), 64'(e_trunc));
      chk("R2", "dmac", 64'(r_dmac), 64'(e_dmac));
      chk("R9", "result cycle", 64'(r_cyc), 64'(bcyc[e_pos] + 1));
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    logic [47:0] mac;
    logic [15:0] body, bad;
    int vids [0:4];
    int parts [0:3];
    int k;
    rst_n = 1'b0; in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_data = 8'h00;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "res_valid in reset", 64'(res_valid), 64'd0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1", "res_valid after reset", 64'(res_valid), 64'd0);
    chk("R1", "in_ready", 64'(in_ready), 64'd1);

    vids[0] = 0; vids[1] = 1; vids[2] = 12'hABC; vids[3] = 12'hFFF; vids[4] = 12'h5A5;
    k = 0;
    // R3: VLAN frames over all priority / DEI values and several IDs
    for (int p = 0; p < 8; p++)
      for (int d = 0; d < 2; d++)
        for (int v = 0; v < 5; v++) begin
          mac = {8'h02, 8'(p), 8'(d), 8'(v), 8'h5C, 8'(k)};
          body = {3'(p), 1'(d), 12'(vids[v])};
          build(mac, 16'h8100, body, 16'h893B, 16'hF123, 16 + (k % 5), 8'(k));
          e_fmt = 2'd1; e_label = {12'h000, 12'(vids[v])}; e_prio = 3'(p); e_dei = 1'(d);
          e_disc = 0; e_trunc = 0; e_pos = 15; exp_dmac(mac, 6);
          send(k[0], k[1] & k[2]);
          check_frame("R3");
          k++;
        end

    parts[0] = 0; parts[1] = 12'h001; parts[2] = 12'h800; parts[3] = 12'hFFF;
    // R4: fine-grained frames, low tag upper nibble differs from priority
    for (int h = 0; h < 4; h++)
      for (int l = 0; l < 4; l++)
        for (int p = 0; p < 8; p++)
          for (int d = 0; d < 2; d++) begin
            mac = {8'hA0, 8'(h), 8'(l), 8'(p), 8'(d), 8'(k)};
            body = {3'(p), 1'(d), 12'(parts[h])};
            build(mac, 16'h893B, body, 16'h893B, {~3'(p), ~1'(d), 12'(parts[l])}, 20 + (k % 4), 8'(k * 3));
            e_fmt = 2'd2; e_label = {12'(parts[h]), 12'(parts[l])}; e_prio = 3'(p); e_dei = 1'(d);
            e_disc = 0; e_trunc = 0; e_pos = 19; exp_dmac(mac, 6);
            send(k[1], k[0] & k[3]);
            check_frame("R4");
            k++;
          end

    // R5: single-bit corruptions of both known type codes, plus all-zero / all-one
    for (int t = 0; t < 34; t++) begin
      if (t < 16) bad = 16'h8100 ^ (16'h1 << t);
      else if (t < 32) bad = 16'h893B ^ (16'h1 << (t - 16));
      else if (t == 32) bad = 16'h0000;
      else bad = 16'hFFFF;
      mac = {8'h10, 8'h20, 8'(t), 8'h40, 8'h50, 8'h60};
      build(mac, bad, 16'hE555, 16'h893B, 16'hE777, 24, 8'(t));
      e_fmt = 2'd3; e_label = '0; e_prio = '0; e_dei = 0;
      e_disc = 1; e_trunc = 0; e_pos = 13; exp_dmac(mac, 6);
      send(t[0], 1'b0);
      check_frame("R5");
    end

    // R6: corrupted second tag type in a fine-grained frame
    for (int t = 0; t < 16; t++) begin
      mac = {8'h33, 8'(t), 8'h44, 8'h55, 8'h66, 8'h77};
      build(mac, 16'h893B, 16'hB123, 16'h893B ^ (16'h1 << t), 16'h0456, 22, 8'(t + 9));
      e_fmt = 2'd3; e_label = '0; e_prio = '0; e_dei = 0;
      e_disc = 1; e_trunc = 0; e_pos = 17; exp_dmac(mac, 6);
      send(t[1], t[0]);
      check_frame("R6");
    end

    // R7: every truncation length of each frame kind, checked up to the full header
    for (int kind = 0; kind < 3; kind++)
      for (int len = 1; len <= 20; len++) begin
        mac = {8'hC0, 8'(kind), 8'(len), 8'hDE, 8'hAD, 8'h01};
        if (kind == 0) build(mac, 16'h8100, 16'h7ABC, 16'h893B, 16'h1111, len, 8'(len));
        else if (kind == 1) build(mac, 16'h893B, 16'h5DEF, 16'h893B, 16'h2345, len, 8'(len));
        else build(mac, 16'h8101, 16'h5DEF, 16'h893B, 16'h2345, len, 8'(len));
        if ((kind == 0 && len <= 15) || (kind == 1 && len <= 19) || (kind == 2 && len <= 13)) begin
          e_fmt = 2'd3; e_label = '0; e_prio = '0; e_dei = 0;
          e_disc = 1; e_trunc = 1; e_pos = len - 1; exp_dmac(mac, len);
          send(len[0], len[1]);
          check_frame("R7");
        end else begin
          exp_dmac(mac, 6);
          if (kind == 0) begin
            e_fmt = 2'd1; e_label = 24'h000ABC; e_prio = 3'd3; e_dei = 1; e_pos = 15;
            e_disc = 0; e_trunc = 0;
          end else if (kind == 1) begin
            e_fmt = 2'd2; e_label = 24'hDEF345; e_prio = 3'd2; e_dei = 1; e_pos = 19;
            e_disc = 0; e_trunc = 0;
          end else begin
            e_fmt = 2'd3; e_label = '0; e_prio = '0; e_dei = 0; e_pos = 13;
            e_disc = 1; e_trunc = 0;
          end
          send(len[0], len[1]);
          check_frame(kind == 2 ? "R5" : (kind == 0 ? "R3" : "R4"));
        end
      end

    // R2 / R9: stray bytes before the start marker, sparse valid cycles
    mac = 48'h0123456789AB;
    build(mac, 16'h893B, 16'h0001, 16'h893B, 16'hF002, 30, 8'h81);
    e_fmt = 2'd2; e_label = 24'h001002; e_prio = 0; e_dei = 0; e_disc = 0; e_trunc = 0;
    e_pos = 19; exp_dmac(mac, 6);
    send(1'b1, 1'b1);
    check_frame("R2");

    // R8: idle period after a frame produces no result
    n_res = 0;
    repeat (10) @(posedge clk);
    #1;
    chk("R8", "no result while idle", 64'(n_res), 64'd0);

    finish_run();
  end
endmodule